// File: doc/BRIEF.md
# Accumulator Move Instruction Executor

This block executes the three data-move operations of a 14-bit accumulator-style instruction set. A fetch stage presents one instruction word at a time together with a valid strobe. Each strobed word is decoded in the same cycle, and the move it names completes at the next rising clock edge. The block holds a single 8-bit working register and an array of 128 eight-bit file registers. Every instruction word carries both its operation code and its operand.

The three operations are: load an 8-bit literal into the working register; copy the working register into a file register; and read a file register, sending the result either to the working register or back into the same file register, as chosen by a destination bit. A word that matches none of the three formats changes no state and raises an illegal-instruction pulse. A combinational test port reads any file register, so the array can be inspected without issuing instructions.

Top module: `movexec_top`

## Requirements
- R1: While the active-low asynchronous reset `rstN` is low, `wReg` is 0, `illegalFlag` is 0, and every file register reads 0 through the test port.
- R2: A valid word with bits 13:10 = 1100 loads bits 7:0 into the working register. Bits 9:8 are ignored and no file register changes.
- R3: A valid word with bits 13:7 = 0000001 copies the working register into the file register addressed by bits 6:0. The working register keeps its value.
- R4: A valid word with bits 13:8 = 001000 and bit 7 = 0 loads the file register addressed by bits 6:0 into the working register.
- R5: A valid word with bits 13:8 = 001000 and bit 7 = 1 writes the file register addressed by bits 6:0 back into itself. Its value and the working register are unchanged.
- R6: A valid word that matches none of the three formats sets `illegalFlag` for exactly the one cycle after the edge that sampled it. It changes neither the working register nor any file register.
- R7: While `instrValid` is low, the working register and the file array hold their values and `illegalFlag` is 0 after the next edge, whatever `instrWord` carries.
- R8: `dbgData` always shows the current contents of the file register selected by `dbgAddr`, with no clock delay. Writes therefore appear on it right after the edge that performs them.
- R9: One instruction completes per clock. An instruction issued in the cycle right after another sees the state that the earlier one left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | High when instrWord is to be executed this cycle |
| instrWord | input | 14 | Instruction word (operation code plus operand) |
| dbgAddr | input | 7 | Test port file register select |
| dbgData | output | 8 | Test port file register contents |
| wReg | output | 8 | Current working register value |
| illegalFlag | output | 1 | One-cycle pulse after an unrecognised valid word |

## Verification
A decode fault that selects the wrong format shows on `wReg` or on `illegalFlag` one cycle after the word is strobed. A fault that writes the wrong file entry, or writes one that should be untouched, shows on `dbgData` as soon as the test port selects that entry. The scoreboard points the test port at the address each instruction touches, so that kind of damage appears on the very edge that causes it. Instructions that are issued back to back expose any stale read of the working register or of the array within two cycles.

// File: rtl/movexec_pkg.sv
package movexec_pkg;
  localparam int INSTR_W = 14;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 7;

  // Opcode prefixes; their lengths and positions are fixed by the encoding
  localparam logic [3:0] LIT_PREFIX   = 4'b1100;     // bits 13:10
  localparam logic [6:0] STORE_PREFIX = 7'b0000001;  // bits 13:7
  localparam logic [5:0] MOVE_PREFIX  = 6'b001000;   // bits 13:8

  typedef struct packed {
    logic loadLit;      // W <= literal
    logic loadFromFile; // W <= file[addr]
    logic storeW;       // file[addr] <= W
    logic writeBack;    // file[addr] <= file[addr]
    logic badOp;        // unrecognised valid word
  } moveStrobe_t;
endpackage

// File: rtl/movexec_ctrl.sv
module movexec_ctrl
  import movexec_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrValid,
  input  logic [IW-1:0] instrWord,
  output moveStrobe_t   strobe,
  output logic [AW-1:0] fileAddr,
  output logic [DW-1:0] literal,
  output logic          illegalQ
);
  logic isLit, isStore, isMove;

  always_comb begin
    isLit   = (instrWord[13:10] == LIT_PREFIX);
    isStore = (instrWord[13:7]  == STORE_PREFIX);
    isMove  = (instrWord[13:8]  == MOVE_PREFIX);
    strobe  = '0;
    if (instrValid) begin
      strobe.loadLit      = isLit;
      strobe.storeW       = isStore;
      strobe.loadFromFile = isMove && !instrWord[7];
      strobe.writeBack    = isMove &&  instrWord[7];
      strobe.badOp        = !(isLit || isStore || isMove);
    end
  end

  assign fileAddr = instrWord[AW-1:0];
  assign literal  = instrWord[DW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= strobe.badOp;
  end
endmodule

// File: rtl/movexec_dp.sv
module movexec_dp
  import movexec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  moveStrobe_t   strobe,
  input  logic [AW-1:0] fileAddr,
  input  logic [DW-1:0] literal,
  input  logic [AW-1:0] dbgAddr,
  output logic [DW-1:0] dbgData,
  output logic [DW-1:0] wQ
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] fileQ [DEPTH];
  logic [DW-1:0] fileRd;
  logic [DW-1:0] fileWrData;
  logic          fileWrEn;

  assign fileRd     = fileQ[fileAddr];
  assign dbgData    = fileQ[dbgAddr];
  assign fileWrEn   = strobe.storeW | strobe.writeBack;
  assign fileWrData = strobe.storeW ? wQ : fileRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    wQ <= '0;
    else if (strobe.loadLit)      wQ <= literal;
    else if (strobe.loadFromFile) wQ <= fileRd;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        fileQ[i] <= '0;
      else if (fileWrEn && (fileAddr == AW'(i)))
        fileQ[i] <= fileWrData;
    end
  end
endmodule

// File: rtl/movexec_top.sv
module movexec_top
  import movexec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  dbgAddr,
  output logic [DATA_W-1:0]  dbgData,
  output logic [DATA_W-1:0]  wReg,
  output logic               illegalFlag
);
  moveStrobe_t        strobe;
  logic [ADDR_W-1:0]  fileAddr;
  logic [DATA_W-1:0]  literal;

  movexec_ctrl #(.IW(INSTR_W), .DW(DATA_W), .AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .strobe(strobe), .fileAddr(fileAddr), .literal(literal),
    .illegalQ(illegalFlag)
  );

  movexec_dp #(.DW(DATA_W), .AW(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fileAddr(fileAddr),
    .literal(literal), .dbgAddr(dbgAddr), .dbgData(dbgData), .wQ(wReg)
  );
endmodule

// File: rtl/movexec_chk.sv
module movexec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [13:0] instrWord,
  input logic [7:0]  wReg,
  input logic        illegalFlag
);
  logic litWord, storeWord, moveWord, keepWord, badWord;
  assign litWord   = instrValid && instrWord[13:10] == 4'b1100;
  assign storeWord = instrValid && instrWord[13:7] == 7'b0000001;
  assign moveWord  = instrWord[13:8] == 6'b001000;
  assign keepWord  = instrValid && moveWord && instrWord[7];
  assign badWord   = instrValid && !(instrWord[13:10] == 4'b1100)
                     && !(instrWord[13:7] == 7'b0000001) && !moveWord;

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (wReg == 8'h00 && !illegalFlag)
        else $error("reset state wrong");
    end
  end

  p_lit_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    litWord |=> wReg == $past(instrWord[7:0]));

  p_store_keeps_w_r3: assert property (@(posedge clk) disable iff (!rstN)
    storeWord |=> wReg == $past(wReg));

  p_writeback_keeps_w_r5: assert property (@(posedge clk) disable iff (!rstN)
    keepWord |=> wReg == $past(wReg));

  p_bad_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    badWord |=> illegalFlag && wReg == $past(wReg));

  p_flag_has_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    illegalFlag |-> $past(badWord));

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> !illegalFlag && $stable(wReg));
endmodule

bind movexec_top movexec_chk u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .wReg(wReg), .illegalFlag(illegalFlag)
);

// File: tb/movexec_top_tb.sv
module movexec_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [13:0] instrWord = '0;
  logic [6:0]  dbgAddr = '0;
  logic [7:0]  dbgData;
  logic [7:0]  wReg;
  logic        illegalFlag;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] w;
    logic       flag;
    logic [7:0] f;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] modW;
  logic [7:0] modF [128];

  always #10 clk = ~clk;

  movexec_top u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .wReg(wReg), .illegalFlag(illegalFlag)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one word for one cycle and pushes the expected result
  task automatic issue(input logic valid, input logic [13:0] word,
                       input logic [6:0] peek, input string tag);
    expItem_t it;
    logic flag = 1'b0;
    @(negedge clk);
    instrValid = valid;
    instrWord  = word;
    dbgAddr    = peek;
    if (valid) begin
      if (word[13:10] == 4'b1100)               modW = word[7:0];
      else if (word[13:7] == 7'b0000001)        modF[word[6:0]] = modW;
      else if (word[13:8] == 6'b001000) begin
        if (!word[7]) modW = modF[word[6:0]];
      end else flag = 1'b1;
    end
    it.w = modW; it.flag = flag; it.f = modF[peek]; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares outputs shortly after the edge that executed the word
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.tag, "wReg", wReg, it.w);
      check(it.tag, "illegalFlag", {7'b0, illegalFlag}, {7'b0, it.flag});
      check(it.tag, "dbgData", dbgData, it.f);
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [13:0] lit(input logic [1:0] dc, input logic [7:0] k);
    return {4'b1100, dc, k};
  endfunction
  function automatic logic [13:0] stw(input logic [6:0] a);
    return {7'b0000001, a};
  endfunction
  function automatic logic [13:0] movf(input logic d, input logic [6:0] a);
    return {6'b001000, d, a};
  endfunction

  initial begin
    modW = '0;
    for (int i = 0; i < 128; i++) modF[i] = '0;

    // R1: reset state, with a legal word presented while reset is held
    instrValid = 1'b1;
    instrWord  = lit(2'b00, 8'hEE);
    repeat (2) @(negedge clk);
    foreach (modF[i]) if (i % 37 == 0 || i == 127) begin
      dbgAddr = 7'(i);
      #1;
      check("R1", "dbgData", dbgData, 8'h00);
    end
    check("R1", "wReg", wReg, 8'h00);
    check("R1", "illegalFlag", {7'b0, illegalFlag}, 8'h00);
    instrValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R2: literal loads, don't-care bits at both extremes
    issue(1'b1, lit(2'b00, 8'h5A), 7'd0, "R2");
    issue(1'b1, lit(2'b11, 8'hA5), 7'd0, "R2");
    // R3: store W to both ends of the array
    issue(1'b1, stw(7'd127), 7'd127, "R3");
    issue(1'b1, lit(2'b01, 8'h3C), 7'd0, "R2");
    issue(1'b1, stw(7'd0), 7'd0, "R3");
    issue(1'b1, stw(7'd16), 7'd16, "R3");
    // R4: file to W
    issue(1'b1, lit(2'b10, 8'h00), 7'd16, "R2");
    issue(1'b1, movf(1'b0, 7'd16), 7'd16, "R4");
    issue(1'b1, movf(1'b0, 7'd127), 7'd127, "R4");
    // R5: write back to the same file register
    issue(1'b1, lit(2'b00, 8'h11), 7'd127, "R2");
    issue(1'b1, movf(1'b1, 7'd127), 7'd127, "R5");
    issue(1'b1, movf(1'b1, 7'd0), 7'd0, "R5");
    // R6: unrecognised encodings, then a quiet cycle to show the pulse ends
    issue(1'b1, 14'h3FFF, 7'd127, "R6");
    issue(1'b1, 14'h0000, 7'd0, "R6");
    issue(1'b1, 14'h0045, 7'd69, "R6");
    issue(1'b1, {6'b001001, 1'b0, 7'd16}, 7'd16, "R6");
    issue(1'b1, {4'b1101, 2'b00, 8'h77}, 7'd16, "R6");
    issue(1'b0, 14'h0000, 7'd16, "R6");
    // R7: words presented without the strobe are ignored
    issue(1'b0, lit(2'b00, 8'hFF), 7'd0, "R7");
    issue(1'b0, stw(7'd0), 7'd0, "R7");
    issue(1'b0, 14'h3FFF, 7'd0, "R7");
    // R8: fill a spread of addresses, then read them back on the test port
    for (int i = 0; i < 16; i++) begin
      issue(1'b1, lit(2'(i), 8'(i * 7 + 3)), 7'(i * 8 + 1), "R8");
      issue(1'b1, stw(7'(i * 8 + 1)), 7'(i * 8 + 1), "R8");
    end
    for (int i = 0; i < 16; i++) issue(1'b0, 14'h0000, 7'(i * 8 + 1), "R8");
    // R9: dependent instructions in consecutive cycles
    issue(1'b1, lit(2'b00, 8'hC3), 7'd50, "R9");
    issue(1'b1, stw(7'd50), 7'd50, "R9");
    issue(1'b1, lit(2'b00, 8'h01), 7'd50, "R9");
    issue(1'b1, movf(1'b0, 7'd50), 7'd50, "R9");
    issue(1'b1, stw(7'd51), 7'd51, "R9");
    issue(1'b1, movf(1'b1, 7'd51), 7'd51, "R9");

    @(negedge clk);
    instrValid = 1'b0;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule